// File: doc/BRIEF.md
# Asynchronous Parallel Memory Bus Master

This block runs a 16-bit asynchronous parallel memory bus from the host side. It drives three active-low strobes: chip enable, write enable and output enable. It takes one read or write request at a time over a valid/ready handshake. Each access passes through three phases: setup, strobe and hold. The length of each phase comes from a configuration count in clock cycles, and a phase lasts that count plus one. The host data bus is split into an output word, an output-enable and an input word. The output-enable must not be asserted while the device may be driving the bus.

Writes come in two shapes. In write-enable-controlled mode, chip enable wraps the write-enable pulse. In chip-enable-controlled mode, write enable wraps the chip-enable pulse. A memory device latches the address at the later of the two falling strobe edges. It latches the data at the earlier of the two rising edges. The shape therefore decides which pin produces each latch event. A companion latch model, `abus_latch_model`, stands in for the device and captures address and data at those combined edges. A bench can then compare the captured values with the request.

Reads hold chip enable low for the whole access and pulse output enable during the strobe phase. The input word is sampled in the last cycle before output enable rises. The result is returned with a one-cycle response pulse.

Top module: `abus_ctrl`

## Requirements
- R1: During a write, output enable stays high, and chip enable and write enable are both low for exactly `cfg_strobe`+1 cycles.
- R2: A write with `cfg_ce_ctl`=0 holds chip enable low for `cfg_setup`+`cfg_strobe`+`cfg_hold`+3 cycles. Write enable is low for `cfg_strobe`+1 cycles only.
- R3: A write with `cfg_ce_ctl`=1 holds write enable low for `cfg_setup`+`cfg_strobe`+`cfg_hold`+3 cycles. Chip enable is low for `cfg_strobe`+1 cycles only.
- R4: In both write modes, a device that latches the address on the later falling edge and the data on the earlier rising edge of chip enable and write enable captures exactly the requested address and data.
- R5: During a read, write enable stays high. Chip enable is low for `cfg_setup`+`cfg_strobe`+`cfg_hold`+3 cycles, and output enable is low for `cfg_strobe`+1 cycles.
- R6: Read data is the value of `mem_dq_in` in the last cycle that output enable is low. `rsp_valid` pulses for exactly one cycle, in the first cycle after output enable rises.
- R7: `mem_dq_oe` is low whenever output enable is low. It is high for every cycle in which a write holds chip enable or write enable low.
- R8: `req_ready` is high only when all three strobes are high. Between two accesses there is at least one cycle with all strobes high.
- R9: `mem_addr` stays constant from the cycle after acceptance until the access ends.
- R10: After reset all strobes are high, `mem_dq_oe` is low, `req_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_setup | input | CW | Setup phase length minus one |
| cfg_strobe | input | CW | Strobe phase length minus one |
| cfg_hold | input | CW | Hold phase length minus one |
| cfg_ce_ctl | input | 1 | Write shape: 1 = chip-enable-controlled, 0 = write-enable-controlled |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Ready for a request (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DW | Read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | AW | Memory address bus |
| mem_dq_out | output | DW | Data driven toward the memory |
| mem_dq_oe | output | 1 | Host drive enable for the data bus |
| mem_dq_in | input | DW | Data returned by the memory |

## Verification
A wrong phase counter or phase state shows up within the same access. One strobe would be low for the wrong number of cycles, or the access would take the wrong total time before `req_ready` returns. A wrong write shape moves the latch events to the wrong cycles, so the latch model captures a wrong address or stale data. The bench sees this when the access completes. A read capture in the wrong cycle picks up the idle pattern the bench places on `mem_dq_in` outside the output-enable window. The read response then carries a wrong value in its first pulse.

// File: rtl/abus_latch_model.sv
module abus_latch_model #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq,
  output logic          cap_valid,
  output logic [AW-1:0] cap_addr,
  output logic [DW-1:0] cap_data
);
  logic          act, act_q;
  logic [AW-1:0] a_q;
  logic [DW-1:0] dq_q;

  assign act = !ce_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= 1'b0;
      a_q       <= '0;
      dq_q      <= '0;
      cap_valid <= 1'b0;
      cap_addr  <= '0;
      cap_data  <= '0;
    end else begin
      act_q     <= act;
      dq_q      <= dq;
      cap_valid <= act_q && !act;
      if (act && !act_q) a_q <= addr;
      if (act_q && !act) begin
        cap_addr <= a_q;
        cap_data <= dq_q;
      end
    end
  end
endmodule

// File: rtl/abus_ctrl.sv
module abus_ctrl #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_strobe,
  input  logic [CW-1:0] cfg_hold,
  input  logic          cfg_ce_ctl,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD} st_t;

  st_t           st, st_nx;
  logic [CW-1:0] cnt, cnt_nx, lim;
  logic          wr_q, cc_q, wr_nx, cc_nx;
  logic          accept, busy_nx, strb_nx, cap;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign wr_nx     = accept ? req_write  : wr_q;
  assign cc_nx     = accept ? cfg_ce_ctl : cc_q;
  assign lim       = (st == ST_SETUP) ? cfg_setup : (st == ST_STROBE) ? cfg_strobe : cfg_hold;
  assign cap       = (st == ST_STROBE) && (cnt == cfg_strobe) && !wr_q;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    if (st == ST_IDLE) begin
      if (req_valid) begin
        st_nx  = ST_SETUP;
        cnt_nx = '0;
      end
    end else if (cnt == lim) begin
      cnt_nx = '0;
      case (st)
        ST_SETUP:  st_nx = ST_STROBE;
        ST_STROBE: st_nx = ST_HOLD;
        default:   st_nx = ST_IDLE;
      endcase
    end else begin
      cnt_nx = cnt + 1'b1;
    end
  end

  assign busy_nx = (st_nx != ST_IDLE);
  assign strb_nx = (st_nx == ST_STROBE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      wr_q       <= 1'b0;
      cc_q       <= 1'b0;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      st        <= st_nx;
      cnt       <= cnt_nx;
      wr_q      <= wr_nx;
      cc_q      <= cc_nx;
      mem_ce_n  <= !(busy_nx && (!(wr_nx && cc_nx) || strb_nx));
      mem_we_n  <= !(busy_nx && wr_nx && (cc_nx || strb_nx));
      mem_oe_n  <= !(strb_nx && !wr_nx);
      mem_dq_oe <= busy_nx && wr_nx;
      rsp_valid <= cap;
      if (cap) rsp_rdata <= mem_dq_in;
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
    end
  end
endmodule

module abus_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_dq_oe,
  input logic [AW-1:0] mem_addr
);
  a_r1_no_we_oe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));
  a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);
  a_r7_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);
  a_r6_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r6_rsp_after_oe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> mem_oe_n && $past(!mem_oe_n));
  a_r8_idle_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n && mem_we_n && mem_oe_n);
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));
endmodule

bind abus_ctrl abus_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/abus_ctrl_bench.sv
module abus_ctrl_bench;
  localparam int AW = 16, DW = 16, CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0;
  logic cfg_ce_ctl = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in, dev_dq;
  logic [AW-1:0] mem_addr, cap_addr;
  logic [DW-1:0] cap_data;
  logic cap_valid;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? (mem_addr ^ 16'h5A3C) : 16'hDEAD;
  assign dev_dq    = mem_dq_oe ? mem_dq_out : 16'hFFFF;

  abus_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u_abus_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe),
    .cfg_hold(cfg_hold), .cfg_ce_ctl(cfg_ce_ctl), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in));

  abus_latch_model #(.AW(AW), .DW(DW)) u_dev (
    .clk(clk), .rst_n(rst_n), .ce_n(mem_ce_n), .we_n(mem_we_n),
    .addr(mem_addr), .dq(dev_dq), .cap_valid(cap_valid),
    .cap_addr(cap_addr), .cap_data(cap_data));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input bit ccm, input int s, input int t, input int h,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n_ce = 0, n_we = 0, n_oe = 0, n_both = 0, n = 0, n_rsp = 0, n_cap = 0;
    int bad_drv = 0, rsp_ok = 0;
    logic prev_oe = 1'b1;
    logic [DW-1:0] got = '0;
    logic [AW-1:0] ca = '0;
    logic [DW-1:0] cd = '0;
    @(negedge clk);
    cfg_setup = CW'(s); cfg_strobe = CW'(t); cfg_hold = CW'(h); cfg_ce_ctl = ccm;
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    forever begin
      @(negedge clk);
      req_valid = 1'b0;
      if (rsp_valid) begin
        n_rsp++; got = rsp_rdata;
        if (!prev_oe && mem_oe_n) rsp_ok = 1;
      end
      if (cap_valid) begin n_cap++; ca = cap_addr; cd = cap_data; end
      if (req_ready || n > 64) break;
      n++;
      if (!mem_ce_n) n_ce++;
      if (!mem_we_n) n_we++;
      if (!mem_oe_n) n_oe++;
      if (!mem_ce_n && !mem_we_n) n_both++;
      if ((!mem_oe_n && mem_dq_oe) || (wr && !mem_dq_oe)) bad_drv++;
      prev_oe = mem_oe_n;
    end
    check(mem_ce_n && mem_we_n && mem_oe_n, "R8 strobes high at idle", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    check(n == s+t+h+3, "R8 access length", n, s+t+h+3);
    check(bad_drv == 0, "R7 bus drive", bad_drv, 0);
    if (wr) begin
      check(n_oe == 0, "R1 OE high in write", n_oe, 0);
      check(n_both == t+1, "R1 overlap width", n_both, t+1);
      if (!ccm) begin
        check(n_ce == s+t+h+3, "R2 CE width", n_ce, s+t+h+3);
        check(n_we == t+1, "R2 WE width", n_we, t+1);
      end else begin
        check(n_we == s+t+h+3, "R3 WE width", n_we, s+t+h+3);
        check(n_ce == t+1, "R3 CE width", n_ce, t+1);
      end
      check(n_cap == 1, "R4 one capture", n_cap, 1);
      check(ca == a, "R4 captured address", ca, a);
      check(cd == d, "R4 captured data", cd, d);
    end else begin
      check(n_we == 0, "R5 WE high in read", n_we, 0);
      check(n_ce == s+t+h+3, "R5 CE width", n_ce, s+t+h+3);
      check(n_oe == t+1, "R5 OE width", n_oe, t+1);
      check(n_rsp == 1 && rsp_ok == 1, "R6 response pulse", n_rsp, 1);
      check(got == (a ^ 16'h5A3C), "R6 read data", got, a ^ 16'h5A3C);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<200000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n, "R10 reset strobes", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    check(!mem_dq_oe && req_ready && !rsp_valid, "R10 reset handshake",
          {mem_dq_oe, req_ready, rsp_valid}, 3'b010);
    rst_n = 1'b1;
    for (int s = 0; s < 3; s++)
      for (int t = 0; t < 3; t++)
        for (int h = 0; h < 3; h++)
          for (int m = 0; m < 2; m++) begin
            logic [AW-1:0] a;
            a = AW'((s*18 + t*6 + h*2 + m) * 16'h0931 + 16'h0101);
            xfer(1'b1, m[0], s, t, h, a, ~a + 16'h1357);
            xfer(1'b0, m[0], s, t, h, a, '0);
          end
    xfer(1'b1, 1'b0, 0, 0, 0, 16'hFFFF, 16'h0000);
    xfer(1'b1, 1'b1, 5, 7, 4, 16'h0000, 16'hFFFF);
    xfer(1'b0, 1'b0, 7, 9, 3, 16'h8001, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule